// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Parallel Receiver with Dual Byte Clocks

This block is the receive half of a 10-bit serial link. It runs on the recovered bit clock and takes one data bit per cycle. Bits arrive least significant first and are shifted into a 10-bit register. Every tenth bit, the register contents are delivered as one parallel word. The block watches the incoming stream for the 8B/10B comma pattern. When it finds one, it moves the word boundary so that the comma opens the next word. A sync-enable input switches this realignment off. With sync disabled, the boundary keeps counting every ten bits from reset, whatever the data holds.

Two byte-rate clocks leave the block. They are complementary, and each one runs at one twentieth of the bit rate. A word completed in the first half of the 20-bit cycle appears on the rising edge of one clock. The next word appears on the rising edge of the other clock. Downstream logic can therefore capture words on two half-rate clocks instead of one full-rate clock.

The core is a two-state half-cycle machine with a bit position counter:
- PH_EVEN is the first half of the 20-bit cycle. In it, `bclk_b` is high.
- PH_ODD is the second half. In it, `bclk_a` is high.
- The transition PH_EVEN to PH_ODD happens when the position counter wraps from 9. The word loads at that edge.
- The transition PH_ODD to PH_EVEN happens on the next wrap, and that word loads with it.
- A realignment only rewrites the position counter and leaves the state as it was.

Top module: `comma_deser`

## Requirements
- R1: Each output word holds ten consecutive received bits, with the earliest-received bit at word bit 0 and the latest at word bit 9.
- R2: With `sync_en` high, a comma in the last seven received bits makes the bit just taken position 6. The comma's first bit then becomes bit 0 of the next word, which follows three bit cycles later. This works for both polarities: oldest-first 0011111 (word[6:0] = 7'b1111100) and 1100000 (word[6:0] = 7'b0000011).
- R3: With `sync_en` low, no realignment occurs. Word boundaries fall every ten bits counted from the first bit after reset, and a comma anywhere in the stream has no effect on them.
- R4: `comma_o` loads together with each word. It is 1 exactly when that word's bits [6:0] equal 7'b1111100 or 7'b0000011.
- R5: `bclk_a` and `bclk_b` are complementary at all times.
- R6: A new word appears only at a rising edge of a byte clock, and successive words alternate between `bclk_a` and `bclk_b`. Between loads, `word_o` and `comma_o` hold their values.
- R7: Without realignment, words come every 10 bit cycles, so each byte clock has a period of 20 bit cycles.
- R8: While reset is low, `word_o` = 0, `comma_o` = 0, `bclk_a` = 0 and `bclk_b` = 1, and the bit position is 0. The first word after reset covers bits 0..9 and rises on `bclk_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one data bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata | input | 1 | Serial data bit, least significant bit of each word first |
| sync_en | input | 1 | Enables comma realignment of the word boundary |
| word_o | output | 10 | Aligned parallel word |
| comma_o | output | 1 | Set when the current word begins with a comma |
| bclk_a | output | 1 | Byte clock that rises with words finished in the first half-cycle |
| bclk_b | output | 1 | Byte clock that rises with words finished in the second half-cycle, complement of `bclk_a` |

## Verification
The bench covers three comma cases with sync enabled:
- A comma already on the boundary, where a design that moved the counter anyway would drop or shift a word.
- A positive-polarity comma three bits off the boundary. Here the realignment lands on an edge that is also a word wrap, so a design that mishandled the clock half or the counter would break the alternation or the 10-cycle spacing.
- A negative-polarity comma four bits off the boundary, which a detector that knew only one polarity would miss, leaving every later word misaligned.

A free-running run with sync disabled places a comma off the boundary. A design that still realigned would emit words that do not match the 10-bit chunks counted from reset, and a flag decoded from the wrong window would mark a misaligned word as a comma.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

    // Width of a comma in bits.
    localparam int COMMA_W = 7;

    // Window bit 0 is the oldest bit received.
    // Positive form, oldest first: 0,0,1,1,1,1,1.
    localparam logic [COMMA_W-1:0] COMMA_POS = {{(COMMA_W-2){1'b1}}, 2'b00};
    // Negative form is the bitwise complement.
    localparam logic [COMMA_W-1:0] COMMA_NEG = ~COMMA_POS;

    // Half of the 20-bit byte-clock cycle.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } half_e;

endpackage

// File: rtl/cd_comma_match.sv
module cd_comma_match
    import comma_deser_pkg::*;
#(
    parameter int W = COMMA_W
) (
    input  logic [W-1:0] win,
    output logic         hit
);

    always_comb begin
        hit = (win == COMMA_POS) || (win == COMMA_NEG);
    end

endmodule

// File: rtl/cd_phase_fsm.sv
module cd_phase_fsm
    import comma_deser_pkg::*;
#(
    parameter int WORD_W      = 10,
    parameter int REALIGN_POS = COMMA_W,
    localparam int PW         = $clog2(WORD_W),
    localparam logic [PW-1:0] LAST   = PW'(WORD_W - 1),
    localparam logic [PW-1:0] RE_POS = PW'(REALIGN_POS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_en,
    input  logic          comma_seen,
    output logic [PW-1:0] pos_o,
    output logic          load_o,
    output half_e         half_o
);

    half_e         half_q, half_d;
    logic [PW-1:0] pos_q, pos_d;
    logic          wrap;

    // State and position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= PH_EVEN;
            pos_q  <= '0;
        end else begin
            half_q <= half_d;
            pos_q  <= pos_d;
        end
    end

    // Next state and next position.
    always_comb begin
        wrap   = (pos_q == LAST);
        half_d = half_q;
        if (wrap) begin
            unique case (half_q)
                PH_EVEN: half_d = PH_ODD;
                PH_ODD:  half_d = PH_EVEN;
            endcase
        end
        if (sync_en && comma_seen) begin
            pos_d = RE_POS;
        end else if (wrap) begin
            pos_d = '0;
        end else begin
            pos_d = pos_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        load_o = wrap;
        half_o = half_q;
        pos_o  = pos_q;
    end

    // R7: the half flips on each wrap and holds otherwise.
    a_r7_half_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == LAST) |=> (half_q != $past(half_q)));
    a_r7_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != LAST) |=> $stable(half_q));
    // R2: a comma seen with sync on moves the position.
    a_r2_realign_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && comma_seen) |=> (pos_q == RE_POS));
    // R3: with sync off, the position only counts.
    a_r3_free_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && (pos_q != LAST)) |=> (pos_q == $past(pos_q) + PW'(1)));

endmodule

// File: rtl/cd_word_cap.sv
module cd_word_cap
    import comma_deser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              load,
    input  logic              head_hit,
    output logic [WORD_W-1:0] sr_next,
    output logic [WORD_W-1:0] word_o,
    output logic              comma_o
);

    logic [WORD_W-1:0] sr_q;

    // New bits enter at the top, so bit 0 is the oldest.
    always_comb begin
        sr_next = {sdata, sr_q[WORD_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '0;
            word_o  <= '0;
            comma_o <= 1'b0;
        end else begin
            sr_q <= sr_next;
            if (load) begin
                word_o  <= sr_next;
                comma_o <= head_hit;
            end
        end
    end

    // R6: the word holds between loads.
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_o));
    // R4: the flag moves only with a word.
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(comma_o));

endmodule

// File: rtl/comma_deser.sv
module comma_deser
    import comma_deser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              sync_en,
    output logic [WORD_W-1:0] word_o,
    output logic              comma_o,
    output logic              bclk_a,
    output logic              bclk_b
);

    localparam int PW = $clog2(WORD_W);

    logic [WORD_W-1:0] sr_next;
    logic              tail_hit, head_hit, load;
    logic [PW-1:0]     pos;
    half_e             half;

    // Newest seven bits: realignment trigger.
    cd_comma_match #(.W(COMMA_W)) u_tail (
        .win (sr_next[WORD_W-1 -: COMMA_W]),
        .hit (tail_hit)
    );

    // Oldest seven bits: flag for a completed word.
    cd_comma_match #(.W(COMMA_W)) u_head (
        .win (sr_next[COMMA_W-1:0]),
        .hit (head_hit)
    );

    cd_phase_fsm #(.WORD_W(WORD_W), .REALIGN_POS(COMMA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_en    (sync_en),
        .comma_seen (tail_hit),
        .pos_o      (pos),
        .load_o     (load),
        .half_o     (half)
    );

    cd_word_cap #(.WORD_W(WORD_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .load     (load),
        .head_hit (head_hit),
        .sr_next  (sr_next),
        .word_o   (word_o),
        .comma_o  (comma_o)
    );

    always_comb begin
        bclk_a = (half == PH_ODD);
        bclk_b = (half == PH_EVEN);
    end

    // R8: reset state at the block's edge.
    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (word_o == '0 && !comma_o && bclk_b && !bclk_a && pos == '0));

endmodule

// File: tb/sim_comma_deser.sv
`timescale 1ns/100ps
module sim_comma_deser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b0;
    logic       sync_en = 1'b1;
    logic [9:0] word_o;
    logic       comma_o, bclk_a, bclk_b;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  armed = 1'b0;
    bit  freerun = 1'b0;
    bit  done = 1'b0;
    logic [10:0] exp_q[$];
    bit  hist[$];

    always #2.5 clk = ~clk;

    comma_deser u0 (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sync_en(sync_en),
        .word_o(word_o), .comma_o(comma_o), .bclk_a(bclk_a), .bclk_b(bclk_b)
    );

    function automatic bit is_comma(input logic [9:0] w);
        return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ctl: 0 none, 1 arm the monitor, 2 disarm it
    task automatic send_bit(input logic b, input int ctl);
        logic [9:0] w;
        @(negedge clk);
        if (ctl == 1) armed = 1'b1;
        if (ctl == 2) armed = 1'b0;
        rst_n = 1'b1;
        sdata = b;
        hist.push_back(b);
        if (freerun && (hist.size() % 10 == 0)) begin
            for (int i = 0; i < 10; i++) w[i] = hist[hist.size() - 10 + i];
            exp_q.push_back({is_comma(w), w});
        end
    endtask

    task automatic send_word(input logic [9:0] w, input bit expect_it, input bit arm7);
        if (expect_it) exp_q.push_back({is_comma(w), w});
        for (int i = 0; i < 10; i++) send_bit(w[i], (arm7 && i == 7) ? 1 : 0);
    endtask

    task automatic do_reset(input logic sync);
        @(negedge clk);
        armed = 1'b0;
        rst_n = 1'b0;
        sync_en = sync;
        hist.delete();
        repeat (3) @(negedge clk);
        chk(word_o == 10'h000, "R8 word in reset", word_o, 0);
        chk(comma_o == 1'b0, "R8 flag in reset", comma_o, 0);
        chk(bclk_a == 1'b0 && bclk_b == 1'b1, "R8 byte clocks in reset", {bclk_a, bclk_b}, 1);
    endtask

    // Monitor: pops the expected word at each byte-clock rise.
    int   cyc = 0;
    int   last_cyc = 0;
    bit   have_prev = 1'b0;
    bit   last_b = 1'b0;
    logic pa = 1'b0, pb = 1'b1;
    logic [10:0] cur;
    always @(posedge clk) begin
        #1;
        cyc++;
        if (armed && ((bclk_a && !pa) || (bclk_b && !pb))) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected word", word_o, 0);
            end else begin
                cur = exp_q.pop_front();
                chk(word_o == cur[9:0], "R1/R2/R3 word value", word_o, cur[9:0]);
                chk(comma_o == cur[10], "R4 comma flag", comma_o, cur[10]);
            end
            chk(bclk_a != bclk_b, "R5 clocks complementary", {bclk_a, bclk_b}, {bclk_a, ~bclk_a});
            if (have_prev) begin
                chk((bclk_a && !pa) == last_b, "R6 alternating clock", bclk_a, last_b);
                chk(cyc - last_cyc == 10, "R7 word spacing", cyc - last_cyc, 10);
            end else if (freerun) begin
                chk(bclk_a && !pa, "R8 first word on bclk_a", bclk_a, 1);
            end
            have_prev = 1'b1;
            last_b = bclk_b && !pb;
            last_cyc = cyc;
        end else if (armed && have_prev) begin
            chk(word_o == cur[9:0], "R6 word held", word_o, cur[9:0]);
        end else if (!armed) begin
            have_prev = 1'b0;
        end
        pa = bclk_a;
        pb = bclk_b;
    end

    initial begin
        // R2: comma already on the boundary.
        do_reset(1'b1);
        send_word(10'h17C, 1'b1, 1'b1);
        send_word(10'h155, 1'b1, 1'b0);
        send_word(10'h2AA, 1'b1, 1'b0);
        // R2: positive comma three bits off the boundary.
        send_bit(1'b1, 2);
        send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        send_word(10'h17C, 1'b1, 1'b1);
        send_word(10'h333, 1'b1, 1'b0);
        send_word(10'h0CC, 1'b1, 1'b0);
        // R2: negative comma four bits off the boundary.
        send_bit(1'b1, 2);
        send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        send_word(10'h283, 1'b1, 1'b1);
        send_word(10'h199, 1'b1, 1'b0);
        send_word(10'h266, 1'b1, 1'b0);
        send_word(10'h155, 1'b1, 1'b0);
        send_bit(1'b0, 2);
        chk(exp_q.size() == 0, "R2 all aligned words seen", exp_q.size(), 0);

        // R3: sync off, comma off the boundary, chunks counted from reset.
        do_reset(1'b0);
        freerun = 1'b1;
        send_bit(1'b1, 1);
        send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        send_word(10'h17C, 1'b0, 1'b0);
        send_word(10'h155, 1'b0, 1'b0);
        send_word(10'h2AA, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) send_bit(i[0] ? 1'b0 : 1'b1, 0);
        repeat (2) @(negedge clk);
        armed = 1'b0;
        freerun = 1'b0;
        chk(exp_q.size() == 0, "R3 all free-run words seen", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule